// File: doc/BRIEF.md
# Event Counter and Timestamp Unit

This block counts hardware events for software profiling. It has a parameterised number of 40-bit event counters, two by default, and one free-running 64-bit timestamp counter. Each event counter has its own select register. The select register names one line of an event bus and sets the counting mode. In occurrence mode the counter adds one for each low-to-high transition of the chosen line. In duration mode it adds one for each clock cycle the line is high.

Software controls the block through a single-cycle write port. The write address picks either a select register or a counter. A separate combinational read port returns any counter, or the timestamp, as a high 32-bit word and a low 32-bit word. The timestamp clears on reset and then advances on every clock edge. Nothing can write it.

Top module: `evtcnt_unit`

## Requirements
- R1: While reset is asserted and right after it, every counter, every select register and the timestamp read as zero.
- R2: The timestamp increases by exactly one on every clock edge after reset and has no other way to change.
- R3: Occurrence mode is select bit 4 = 0. With enable (select bit 5 = 1), a counter adds one on the edge where the chosen event line is 1 and was 0 at the previous edge. A line that stays high adds nothing more. The event index is select bits 3:0, and the event history is zero at reset.
- R4: Duration mode is select bit 4 = 1. With enable, a counter adds one on every edge at which the chosen event line is 1.
- R5: With the enable bit 0, a counter keeps its value whatever its event line does.
- R6: A write whose address bit 1 is 1 loads counter `wr_addr[0]` with bits 39:0 of `wr_data`. The upper bits are dropped, and the load wins over an increment in the same cycle.
- R7: A counter at 2^40-1 that increments becomes 0.
- R8: Read code 0 or 1 returns that counter, with bits 39:32 in `rd_hi[7:0]`, `rd_hi[31:8]` = 0, and bits 31:0 in `rd_lo`. Code 2 returns timestamp bits 63:32 and 31:0. Code 3 reads as zero.
- R9: A write with address bit 1 equal to 0 loads select register `wr_addr[0]` from `wr_data[5:0]`. The new setting governs counting from the next edge on. An event index of 8 or more never counts.
- R10: Each counter follows only its own select register and its own writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_bus | input | 8 | Event lines, one bit per event |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Bit 1: 1 = counter, 0 = select register; bit 0: counter number |
| wr_data | input | 64 | Write data |
| rd_addr | input | 2 | Read code: 0/1 counter, 2 timestamp, 3 unused |
| rd_hi | output | 32 | Upper word of the selected value |
| rd_lo | output | 32 | Lower word of the selected value |

## Verification
The read port is combinational, so a wrong counter state shows at `rd_hi`/`rd_lo` in the cycle after the edge that caused it. A stale event history shows up as an extra or missing count on the edge after a line rises. A select register that took the wrong bits shows up as a counter that follows the wrong line or counts in the wrong mode, starting one edge after the write. A wrong wrap or truncation of written data appears as soon as the counter is read.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

  // Select register field layout
  localparam int SEL_IDX_W    = 4;
  localparam int SEL_MODE_BIT = 4;
  localparam int SEL_EN_BIT   = 5;
  localparam int SEL_W        = 6;

  typedef enum logic {
    CNT_OCCUR    = 1'b0,
    CNT_DURATION = 1'b1
  } cnt_mode_e;

  typedef struct packed {
    logic                 enable;
    cnt_mode_e            mode;
    logic [SEL_IDX_W-1:0] idx;
  } evsel_t;

  // Increment modulo 2**w (w <= 64)
  function automatic logic [63:0] wrap_inc(input logic [63:0] v, input int unsigned w);
    logic [63:0] mask;
    mask = (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    return (v + 64'd1) & mask;
  endfunction

  // Upper half of a 64-bit value
  function automatic logic [31:0] upper_word(input logic [63:0] v);
    return v[63:32];
  endfunction

  // Lower half of a 64-bit value
  function automatic logic [31:0] lower_word(input logic [63:0] v);
    return v[31:0];
  endfunction

endpackage

// File: rtl/evtcnt_edge.sv
module evtcnt_edge #(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [NUM_EVT-1:0] evt_rise
);

  logic [NUM_EVT-1:0] evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_in;
  end

  assign evt_rise = evt_in & ~evt_q;

endmodule

// File: rtl/evtcnt_tstamp.sv
module evtcnt_tstamp #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);
  import evtcnt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else        ts <= TS_W'(wrap_inc(64'(ts), TS_W));
  end

endmodule

// File: rtl/evtcnt_slice.sv
module evtcnt_slice #(
  parameter int CTR_W   = 40,
  parameter int NUM_EVT = 8,
  parameter int DATA_W  = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_wr,
  input  logic                  ctr_wr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NUM_EVT-1:0]    evt_now,
  input  logic [NUM_EVT-1:0]    evt_rise,
  output logic [CTR_W-1:0]      cnt,
  output evtcnt_pkg::evsel_t    sel_q,
  output logic                  tick
);
  import evtcnt_pkg::*;

  logic pick_lvl;
  logic pick_rise;

  // Event selection; indices beyond the bus select nothing
  always_comb begin
    pick_lvl  = 1'b0;
    pick_rise = 1'b0;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (sel_q.idx == SEL_IDX_W'(e)) begin
        pick_lvl  = evt_now[e];
        pick_rise = evt_rise[e];
      end
    end
  end

  assign tick = sel_q.enable & ((sel_q.mode == CNT_DURATION) ? pick_lvl : pick_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= evsel_t'(wdata[SEL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (ctr_wr) cnt <= wdata[CTR_W-1:0];
    else if (tick)   cnt <= CTR_W'(wrap_inc(64'(cnt), CTR_W));
  end

endmodule

// File: rtl/evtcnt_unit.sv
module evtcnt_unit #(
  parameter int NUM_CTR = 2,
  parameter int CTR_W   = 40,
  parameter int TS_W    = 64,
  parameter int NUM_EVT = 8,
  parameter int WORD_W  = 32,
  localparam int CIDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int WA_W   = CIDX_W + 1,
  localparam int RA_W   = $clog2(NUM_CTR + 2),
  localparam int DATA_W = 2 * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_bus,
  input  logic               wr_en,
  input  logic [WA_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [RA_W-1:0]    rd_addr,
  output logic [WORD_W-1:0]  rd_hi,
  output logic [WORD_W-1:0]  rd_lo
);
  import evtcnt_pkg::*;

  // Named internal events for the checker
  logic [NUM_EVT-1:0]            evt_rise;
  logic [NUM_CTR-1:0]            ctr_tick;
  logic [NUM_CTR-1:0]            ctr_wr_hit;
  logic [NUM_CTR-1:0]            sel_wr_hit;
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all;
  logic [NUM_CTR-1:0][SEL_W-1:0] sel_all;
  logic [TS_W-1:0]               ts_val;

  evtcnt_edge #(.NUM_EVT(NUM_EVT)) u_edge (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_bus), .evt_rise(evt_rise)
  );

  evtcnt_tstamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .ts(ts_val)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    evsel_t sel_i;

    assign ctr_wr_hit[i] = wr_en &  wr_addr[WA_W-1] & (wr_addr[CIDX_W-1:0] == CIDX_W'(i));
    assign sel_wr_hit[i] = wr_en & ~wr_addr[WA_W-1] & (wr_addr[CIDX_W-1:0] == CIDX_W'(i));
    assign sel_all[i]    = sel_i;

    evtcnt_slice #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr   (sel_wr_hit[i]),
      .ctr_wr   (ctr_wr_hit[i]),
      .wdata    (wr_data),
      .evt_now  (evt_bus),
      .evt_rise (evt_rise),
      .cnt      (cnt_all[i]),
      .sel_q    (sel_i),
      .tick     (ctr_tick[i])
    );
  end

  // Read mux: counters zero-extended, then timestamp, else zero
  always_comb begin
    logic [63:0] wide;
    wide = '0;
    if (rd_addr == RA_W'(NUM_CTR)) wide = 64'(ts_val);
    for (int i = 0; i < NUM_CTR; i++) begin
      if (rd_addr == RA_W'(i)) wide = 64'(cnt_all[i]);
    end
    rd_hi = WORD_W'(upper_word(wide));
    rd_lo = WORD_W'(lower_word(wide));
  end

endmodule

// File: rtl/evtcnt_checker.sv
module evtcnt_checker #(
  parameter int NUM_CTR = 2,
  parameter int CTR_W   = 40,
  parameter int TS_W    = 64,
  parameter int NUM_EVT = 8,
  parameter int WORD_W  = 32,
  parameter int RA_W    = 2,
  parameter int DATA_W  = 64
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic [NUM_EVT-1:0]                        evt_bus,
  input logic [DATA_W-1:0]                         wr_data,
  input logic [RA_W-1:0]                           rd_addr,
  input logic [WORD_W-1:0]                         rd_hi,
  input logic [TS_W-1:0]                           ts_val,
  input logic [NUM_CTR-1:0][CTR_W-1:0]             cnt_all,
  input logic [NUM_CTR-1:0][evtcnt_pkg::SEL_W-1:0] sel_all,
  input logic [NUM_CTR-1:0]                        ctr_tick,
  input logic [NUM_CTR-1:0]                        ctr_wr_hit
);
  import evtcnt_pkg::*;

  logic               past_valid;
  logic [NUM_EVT-1:0] evt_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_valid <= 1'b0;
      evt_seen   <= '0;
    end else begin
      past_valid <= 1'b1;
      evt_seen   <= evt_bus;
    end
  end

  assert_ts_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> ts_val == TS_W'($past(ts_val) + 1'b1));

  assert_hi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr < RA_W'(NUM_CTR)) |-> rd_hi[WORD_W-1:CTR_W-WORD_W] == '0);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    logic                 lvl_now;
    logic                 lvl_old;
    logic                 idx_ok;
    logic [SEL_IDX_W-1:0] idx;

    assign idx = sel_all[i][SEL_IDX_W-1:0];

    always_comb begin
      lvl_now = 1'b0;
      lvl_old = 1'b0;
      idx_ok  = 1'b0;
      for (int e = 0; e < NUM_EVT; e++) begin
        if (idx == SEL_IDX_W'(e)) begin
          lvl_now = evt_bus[e];
          lvl_old = evt_seen[e];
          idx_ok  = 1'b1;
        end
      end
    end

    assert_occ_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_tick[i] && !sel_all[i][SEL_MODE_BIT]) |-> (lvl_now && !lvl_old));

    assert_dur_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_tick[i] && sel_all[i][SEL_MODE_BIT]) |-> lvl_now);

    assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_tick[i] |-> sel_all[i][SEL_EN_BIT]);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && !$past(ctr_tick[i]) && !$past(ctr_wr_hit[i])) |-> cnt_all[i] == $past(cnt_all[i]));

    assert_wr_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(ctr_wr_hit[i])) |-> cnt_all[i] == $past(wr_data[CTR_W-1:0]));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(ctr_tick[i] && !ctr_wr_hit[i] && (&cnt_all[i]))) |-> cnt_all[i] == '0);

    assert_sel_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_tick[i] |-> idx_ok);
  end

endmodule

bind evtcnt_unit evtcnt_checker #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .TS_W(TS_W), .NUM_EVT(NUM_EVT),
  .WORD_W(WORD_W), .RA_W(RA_W), .DATA_W(DATA_W)
) u_evtcnt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_bus    (evt_bus),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_hi      (rd_hi),
  .ts_val     (ts_val),
  .cnt_all    (cnt_all),
  .sel_all    (sel_all),
  .ctr_tick   (ctr_tick),
  .ctr_wr_hit (ctr_wr_hit)
);

// File: tb/test_evtcnt_unit.sv
module test_evtcnt_unit;

  localparam logic [63:0] MASK40 = (64'd1 << 40) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_bus = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_hi;
  logic [31:0] rd_lo;

  int n_checks = 0;
  int n_fail   = 0;

  // Reference state
  logic [63:0] m_cnt [2];
  logic [5:0]  m_sel [2];
  logic [63:0] m_ts;
  logic [7:0]  m_prev;

  always #10 clk = ~clk;

  evtcnt_unit i_evtcnt_unit (
    .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  function automatic logic pick(input logic [7:0] v, input logic [3:0] idx);
    return (idx < 4'd8) ? v[idx[2:0]] : 1'b0;
  endfunction

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
    m_ts = '0;
    m_prev = '0;
  endtask

  // One clock: drive at negedge, update model at the edge, return at next negedge
  task automatic step(input logic we, input logic [1:0] wa, input logic [63:0] wd, input logic [7:0] ev);
    logic tk;
    wr_en = we; wr_addr = wa; wr_data = wd; evt_bus = ev;
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      logic lv, pv;
      lv = pick(ev, m_sel[i][3:0]);
      pv = pick(m_prev, m_sel[i][3:0]);
      tk = m_sel[i][5] && (m_sel[i][4] ? lv : (lv && !pv));
      if (we && wa[1] && wa[0] == i[0])      m_cnt[i] = wd & MASK40;
      else if (tk)                           m_cnt[i] = (m_cnt[i] + 64'd1) & MASK40;
      if (we && !wa[1] && wa[0] == i[0])     m_sel[i] = wd[5:0];
    end
    m_prev = ev;
    m_ts = m_ts + 64'd1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_reads(input string req);
    for (int a = 0; a < 4; a++) begin
      logic [63:0] e;
      rd_addr = a[1:0];
      #1;
      e = (a < 2) ? m_cnt[a] : (a == 2) ? m_ts : 64'd0;
      check(req, rd_hi, e[63:32]);
      check(req, rd_lo, e[31:0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reads("R1 reset state");
    rst_n = 1'b1;
    check_reads("R1 after release");

    // R2 timestamp advance
    for (int k = 0; k < 5; k++) step(1'b0, 2'b00, '0, 8'h00);
    check_reads("R2 timestamp");
    rd_addr = 2'd2; #1;
    check("R2 five edges", rd_lo, 32'd5);

    // R3 occurrence on event 3, R10 counter 1 untouched
    step(1'b1, 2'b00, 64'h23, 8'h00);
    step(1'b0, 2'b00, '0, 8'h08);
    step(1'b0, 2'b00, '0, 8'h08);
    step(1'b0, 2'b00, '0, 8'h08);
    step(1'b0, 2'b00, '0, 8'h00);
    step(1'b0, 2'b00, '0, 8'h08);
    check_reads("R3 occurrence");
    rd_addr = 2'd0; #1;
    check("R3 two rising edges", rd_lo, 32'd2);
    rd_addr = 2'd1; #1;
    check("R10 idle counter", rd_lo, 32'd0);

    // R4 duration on event 5 for counter 1
    step(1'b1, 2'b01, 64'h35, 8'h00);
    for (int k = 0; k < 4; k++) step(1'b0, 2'b00, '0, 8'h20);
    step(1'b0, 2'b00, '0, 8'h00);
    check_reads("R4 duration");
    rd_addr = 2'd1; #1;
    check("R4 four high cycles", rd_lo, 32'd4);

    // R5 disable counter 0 then toggle its event
    step(1'b1, 2'b00, 64'h03, 8'h00);
    for (int k = 0; k < 6; k++) step(1'b0, 2'b00, '0, (k % 2) ? 8'h08 : 8'h00);
    check_reads("R5 disabled hold");
    rd_addr = 2'd0; #1;
    check("R5 value kept", rd_lo, 32'd2);

    // R6 write wins over a duration tick; upper bits dropped
    step(1'b1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 8'h20);
    check_reads("R6 write priority");
    rd_addr = 2'd1; #1;
    check("R6 low 40 bits hi", rd_hi, 32'h0000_00FF);

    // R7 wrap through max
    step(1'b1, 2'b11, 64'h00FF_FFFF_FFFE, 8'h20);
    step(1'b0, 2'b00, '0, 8'h20);
    rd_addr = 2'd1; #1;
    check("R7 at max lo", rd_lo, 32'hFFFF_FFFF);
    step(1'b0, 2'b00, '0, 8'h20);
    rd_addr = 2'd1; #1;
    check("R7 wrapped hi", rd_hi, 32'd0);
    check("R7 wrapped lo", rd_lo, 32'd0);
    check_reads("R7 wrap");

    // R9 select timing: enabling during a high event counts from next edge
    step(1'b1, 2'b00, 64'h33, 8'h08);
    rd_addr = 2'd0; #1;
    check("R9 no count in write cycle", rd_lo, 32'd2);
    step(1'b0, 2'b00, '0, 8'h08);
    rd_addr = 2'd0; #1;
    check("R9 count next edge", rd_lo, 32'd3);
    // R9 out-of-range index never counts
    step(1'b1, 2'b00, 64'h3C, 8'hFF);
    for (int k = 0; k < 4; k++) step(1'b0, 2'b00, '0, 8'hFF);
    check_reads("R9 index out of range");

    // R8 unused read code and field layout, plus mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic we;
      we = ($urandom % 6) == 0;
      step(we, 2'($urandom), {$urandom, $urandom}, 8'($urandom));
      if (k % 4 == 0) check_reads("R8 R10 random");
    end

    finish_up();
  end

endmodule